// File: doc/BRIEF.md
# Multi-drop Serial Register Write Port

This block is the slave side of a three-wire control bus (serial clock, serial data, frame enable). Up to three identical devices can share the bus. Each device learns its own two-bit identity from a board strap. The strap arrives already decoded into two bits. A frame is sixteen bits long and is sent most significant bit first. The first byte is the address byte: the identity field, then a read flag, then the register index. The second byte is the data. When the enable line rises, the frame is checked. If it is a write, has exactly sixteen bits, and is meant for this device, it is committed into a small bank of eight-bit registers.

The bus pins have no timing relation to the system clock. Each one passes through a two-stage synchronizer and an edge detector before the shift logic sees it. An identity field of `11` is a broadcast and is accepted by every device. Writing to register index 31 is a soft reset: on the next cycle it returns the whole bank to its defaults. The serial bus has no back-pressure. The block accepts every frame that the host clocks in, so the host only has to keep SCK slow enough for the synchronizers (at least three system clocks per SCK level).

Top module: `mdrop_reg_port`

## Requirements
- R1: While `rst_n` is low, and after it is released, register i holds its default value `0x5A XOR (0x11*i)`, truncated to 8 bits.
- R2: SDI is sampled on each rising SCK edge while SEN is low. The first byte is the address byte, bits 15..8 = {id[1], id[0], idx[4], rd, idx[3], idx[2], idx[1], idx[0]}. The second byte is the data byte, bits 7..0. Both bytes are sent MSB first.
- R3: Register contents change only as the result of a rising edge on SEN. Clocking in a complete frame does not change a register until SEN rises.
- R4: A frame is committed only if exactly 16 SCK rising edges occurred while SEN was low. A frame of 0, 15 or 17 bits changes nothing. The bit count is cleared while SEN is high.
- R5: A write frame whose id field equals `dev_id` updates the addressed register.
- R6: A write frame with id field `11` updates the addressed register whatever `dev_id` is.
- R7: A write frame whose id field is neither `dev_id` nor `11` changes nothing.
- R8: A frame with rd = 1 (address bit 12) changes nothing.
- R9: A frame that is accepted for index 31 restores every register to its default, one clock after the cycle in which an ordinary write to a register would have become visible.
- R10: An accepted frame whose index is NREGS or more, and not 31, changes nothing.
- R11: An accepted write appears on `regs_o` after the third rising `clk` edge that follows the SEN pin going high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_id | input | 2 | Decoded strap identity of this device (00, 01, 10) |
| sck | input | 1 | Serial bus clock, asynchronous to `clk` |
| sdi | input | 1 | Serial bus data |
| sen | input | 1 | Frame enable: low while shifting, rising edge commits |
| regs_o | output | NREGS*8 | Register bank contents, register i in bits [8i+7:8i] |

## Verification
The bench sends matched-identity, broadcast, foreign-identity and read-flagged frames to different registers. Each one then shows up as exactly one register change or no change at all. Frames of 0, 15 and 17 bits are used to tell a commit gated by the bit count apart from one that fires on any SEN edge. An index beyond the bank is sent to show that unused indices are dropped. A soft-reset frame that follows several writes shows that the whole bank returns to its defaults one cycle after the commit. A long pause between the last bit and the SEN rise shows that a frame is not committed early.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  localparam int FRAME_BITS = 16;
  localparam logic [1:0] BCAST_ID = 2'b11;
  localparam logic [4:0] SRST_IDX = 5'd31;

  typedef struct packed {
    logic [1:0] id;
    logic       idx_hi;
    logic       rd;
    logic [3:0] idx_lo;
  } addr_byte_t;

  function automatic logic [7:0] dflt_val(int i);
    return 8'h5A ^ 8'(8'h11 * i);
  endfunction
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              q_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      q_d   <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      q_d   <= chain[STAGES-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign rise = q & ~q_d;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int FRAME_BITS = 16,
  localparam int CW = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  shift,
  input  logic                  din,
  output logic [FRAME_BITS-1:0] word,
  output logic [CW-1:0]         cnt
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
    end else if (clr) begin
      word <= '0;
      cnt  <= '0;
    end else if (shift) begin
      word <= {word[FRAME_BITS-2:0], din};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/frame_decoder.sv
module frame_decoder
  import mdrop_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int CW = $clog2(FRAME_BITS + 2)
) (
  input  logic                  commit,
  input  logic [FRAME_BITS-1:0] word,
  input  logic [CW-1:0]         cnt,
  input  logic [1:0]            dev_id,
  output logic                  wr_en,
  output logic [4:0]            wr_idx,
  output logic [7:0]            wr_data,
  output logic                  srst
);
  localparam logic [4:0]    NREGS_L = 5'(NREGS);
  localparam logic [CW-1:0] FULL    = CW'(FRAME_BITS);

  addr_byte_t abyte;
  logic       accept;

  always_comb begin
    abyte   = addr_byte_t'(word[15:8]);
    wr_data = word[7:0];
    wr_idx  = {abyte.idx_hi, abyte.idx_lo};
    accept  = commit && (cnt == FULL) && !abyte.rd &&
              ((abyte.id == dev_id) || (abyte.id == BCAST_ID));
    wr_en   = accept && (wr_idx < NREGS_L);
    srst    = accept && (wr_idx == SRST_IDX);
  end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import mdrop_pkg::*;
#(
  parameter int NREGS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [4:0]         wr_idx,
  input  logic [7:0]         wr_data,
  input  logic               srst,
  output logic               rst_pend,
  output logic [NREGS*8-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pend <= 1'b0;
    else        rst_pend <= srst;
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            q[g*8 +: 8] <= dflt_val(g);
      else if (rst_pend)                     q[g*8 +: 8] <= dflt_val(g);
      else if (wr_en && wr_idx == 5'(g))     q[g*8 +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/mdrop_reg_port.sv
module mdrop_reg_port
  import mdrop_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         dev_id,
  input  logic               sck,
  input  logic               sdi,
  input  logic               sen,
  output logic [NREGS*8-1:0] regs_o
);
  localparam int CW = $clog2(FRAME_BITS + 2);

  logic                  sck_s, sck_rise;
  logic                  sdi_s, sdi_unused;
  logic                  sen_s, sen_rise;
  logic [FRAME_BITS-1:0] word;
  logic [CW-1:0]         cnt;
  logic                  wr_en, srst, rst_pend;
  logic [4:0]            wr_idx;
  logic [7:0]            wr_data;

  sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck (
    .clk(clk), .rst_n(rst_n), .d(sck), .q(sck_s), .rise(sck_rise));
  sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi (
    .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s), .rise(sdi_unused));
  sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sen (
    .clk(clk), .rst_n(rst_n), .d(sen), .q(sen_s), .rise(sen_rise));

  frame_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(sen_s), .shift(sck_rise), .din(sdi_s),
    .word(word), .cnt(cnt));

  frame_decoder #(.NREGS(NREGS)) u_dec (
    .commit(sen_rise), .word(word), .cnt(cnt), .dev_id(dev_id),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .srst(srst));

  reg_bank #(.NREGS(NREGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .srst(srst), .rst_pend(rst_pend), .q(regs_o));
endmodule

// File: rtl/mdrop_reg_port_chk.sv
module mdrop_reg_port_chk
  import mdrop_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int CW = $clog2(FRAME_BITS + 2)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sen_s,
  input logic               sen_rise,
  input logic [CW-1:0]      cnt,
  input logic               rst_pend,
  input logic [NREGS*8-1:0] regs
);
  function automatic logic [NREGS*8-1:0] dflt_vec();
    logic [NREGS*8-1:0] v;
    for (int i = 0; i < NREGS; i++) v[i*8 +: 8] = dflt_val(i);
    return v;
  endfunction

  // R3
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sen_rise) && !$past(rst_pend)) |-> $stable(regs));

  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sen_s |=> (cnt == '0));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ((cnt == '0) || (cnt == CW'($past(cnt) + 1'b1))));

  // R9
  srst_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |=> (regs == dflt_vec()));
endmodule

bind mdrop_reg_port mdrop_reg_port_chk #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sen_s(sen_s), .sen_rise(sen_rise),
  .cnt(cnt), .rst_pend(rst_pend), .regs(regs_o));

// File: tb/test_mdrop_reg_port.sv
module test_mdrop_reg_port;
  localparam int NREGS = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [1:0]         dev_id = 2'b01;
  logic               sck = 1'b0, sdi = 1'b0, sen = 1'b1;
  logic [NREGS*8-1:0] regs_o;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  bit    done = 0;

  logic [7:0] model [NREGS];
  int due_q[$], idx_q[$], val_q[$];

  always #4 clk = ~clk;

  mdrop_reg_port #(.NREGS(NREGS)) i_mdrop_reg_port (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .sck(sck), .sdi(sdi),
    .sen(sen), .regs_o(regs_o));

  function automatic logic [7:0] dflt(int i);
    return 8'h5A ^ 8'((17 * i) % 256);
  endfunction

  function automatic logic [15:0] frame(logic [1:0] id, bit rd, int idx, logic [7:0] d);
    logic [4:0] x = 5'(idx);
    return {id, x[4], rd, x[3:0], d};
  endfunction

  task automatic check(bit ok, string req, logic [NREGS*8-1:0] act, logic [NREGS*8-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial for (int i = 0; i < NREGS; i++) model[i] = dflt(i);

  always @(posedge clk) cyc++;

  // per-cycle reference comparison
  always @(negedge clk) begin
    logic [NREGS*8-1:0] exp;
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      if (idx_q[0] < 0) for (int i = 0; i < NREGS; i++) model[i] = dflt(i);
      else model[idx_q[0]] = 8'(val_q[0]);
      void'(due_q.pop_front()); void'(idx_q.pop_front()); void'(val_q.pop_front());
    end
    for (int i = 0; i < NREGS; i++) exp[i*8 +: 8] = model[i];
    if (!done) check(regs_o === exp, cur_req, regs_o, exp);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [15:0] f, int nbits, int hold = 4);
    logic [1:0] id;
    int idx;
    @(negedge clk); sen = 1'b0;
    idle(4);
    for (int b = 0; b < nbits; b++) begin
      sdi = (b < 16) ? f[15-b] : 1'b0;
      idle(4); sck = 1'b1;
      idle(4); sck = 1'b0;
    end
    idle(hold);
    sen = 1'b1;
    id  = f[15:14];
    idx = {f[13], f[11:8]};
    if (nbits == 16 && f[12] == 1'b0 && (id == dev_id || id == 2'b11)) begin
      if (idx < NREGS) begin
        due_q.push_back(cyc + 3); idx_q.push_back(idx); val_q.push_back(f[7:0]);
      end else if (idx == 31) begin
        due_q.push_back(cyc + 4); idx_q.push_back(-1); val_q.push_back(0);
      end
    end
    idle(10);
  endtask

  task automatic expect_reg(int i, logic [7:0] v, string req);
    check(regs_o[i*8 +: 8] === v, req, 64'(regs_o[i*8 +: 8]), 64'(v));
  endtask

  initial begin
    idle(5);
    // R1: reset defaults
    for (int i = 0; i < NREGS; i++) expect_reg(i, dflt(i), "R1");
    rst_n = 1'b1;
    idle(3);
    cur_req = "R2/R5/R11";
    send(frame(2'b01, 0, 3, 8'hA5), 16);
    expect_reg(3, 8'hA5, "R5");
    cur_req = "R3";
    send(frame(2'b01, 0, 4, 8'h96), 16, 40);
    expect_reg(4, 8'h96, "R3");
    cur_req = "R6";
    send(frame(2'b11, 0, 0, 8'h3C), 16);
    expect_reg(0, 8'h3C, "R6");
    cur_req = "R7";
    send(frame(2'b10, 0, 1, 8'hFF), 16);
    expect_reg(1, dflt(1), "R7");
    cur_req = "R8";
    send(frame(2'b01, 1, 2, 8'h00), 16);
    expect_reg(2, dflt(2), "R8");
    cur_req = "R4";
    send(frame(2'b01, 0, 5, 8'h11), 15);
    send(frame(2'b01, 0, 5, 8'h22), 17);
    send(frame(2'b01, 0, 5, 8'h33), 0);
    expect_reg(5, dflt(5), "R4");
    cur_req = "R10";
    send(frame(2'b01, 0, 9, 8'h44), 16);
    send(frame(2'b11, 0, 24, 8'h45), 16);
    cur_req = "R5";
    dev_id = 2'b00;
    send(frame(2'b00, 0, 7, 8'h81), 16);
    send(frame(2'b01, 0, 6, 8'h82), 16);
    expect_reg(7, 8'h81, "R5");
    expect_reg(6, dflt(6), "R7");
    cur_req = "R9";
    send(frame(2'b00, 0, 31, 8'h00), 16);
    for (int i = 0; i < NREGS; i++) expect_reg(i, dflt(i), "R9");
    cur_req = "R6";
    dev_id = 2'b10;
    send(frame(2'b11, 0, 2, 8'h5C), 16);
    expect_reg(2, 8'h5C, "R6");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule